// File: doc/BRIEF.md
# Partial Word Merge Sequencer

This block carries out the byte-merging half of the left/right partial-word load and store instructions of a 32-bit little-endian core. A request brings an operation code, a byte address and access to a register value. The block fetches the aligned memory word that contains the addressed byte. It then combines register bytes and memory bytes according to the low address bits. For a load, it returns the merged register value. For a store, it writes the merged word back to the same aligned location.

Every access to memory uses the word-aligned address, so any byte offset is legal and none of them causes an alignment fault. The register operand is taken from `cur_reg` in the cycle the memory word arrives. The merge therefore sees whatever the destination register holds at that moment, including a load that has only just completed. Address generation, the bus fabric and load-delay scheduling belong to the surrounding pipeline.

The sequencer has four named states. IDLE accepts a request (IDLE→READ). READ holds a read request until data is returned. It then goes to WRITE for stores (READ→WRITE) or straight to FINISH for loads (READ→FINISH). WRITE holds the merged word until the write is acknowledged (WRITE→FINISH). FINISH raises `done` for one cycle and returns to IDLE (FINISH→IDLE).

Top module: `pw_merge_unit`

## Requirements
- R1: Every read and every write places `{req_addr[31:2], 2'b00}` on `mem_addr`. This holds for all four byte offsets, and no offset produces any fault or different sequence.
- R2: Operation code 2'b00 (load-left) with offset k = `req_addr[1:0]` returns the register value ANDed with 0x00FFFFFF, 0x0000FFFF, 0x000000FF or 0x00000000 for k = 0, 1, 2, 3. This is ORed with the memory word shifted left by 24, 16, 8 or 0.
- R3: Operation code 2'b01 (load-right) with offset k returns the register value ANDed with 0x00000000, 0xFF000000, 0xFFFF0000 or 0xFFFFFF00 for k = 0, 1, 2, 3. This is ORed with the memory word shifted right by 0, 8, 16 or 24.
- R4: Operation code 2'b10 (store-left) with offset k writes the memory word ANDed with 0xFFFFFF00, 0xFFFF0000, 0xFF000000 or 0x00000000 for k = 0, 1, 2, 3. This is ORed with the register value shifted right by 24, 16, 8 or 0.
- R5: Operation code 2'b11 (store-right) with offset k writes the memory word ANDed with 0x00000000, 0x000000FF, 0x0000FFFF or 0x00FFFFFF for k = 0, 1, 2, 3. This is ORed with the register value shifted left by 0, 8, 16 or 24.
- R6: The register operand is the value on `cur_reg` in the cycle `mem_rvalid` is high during the read. Values presented at any other cycle have no effect on the result.
- R7: A store issues exactly one read and then one write of the merged word to the same aligned address. `mem_rd` and `mem_wr` are never high together. Each request is held, with the address and write data stable, until it is answered. A load never raises `mem_wr`.
- R8: `done` is a single-cycle pulse. It comes the cycle after the write acknowledge for a store, and the cycle after read data for a load. `ld_result` then shows the load result and keeps it through later stores until the next load completes.
- R9: After reset, `req_ready` is high and `mem_rd`, `mem_wr`, `done` and `ld_result` are zero. `req_ready` is high only in IDLE and low while an operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | bit1: store, bit0: right variant |
| req_addr | input | 32 | Byte address of the partial access |
| cur_reg | input | 32 | Live register operand (destination for loads, source for stores) |
| mem_rd | output | 1 | Read request, held until `mem_rvalid` |
| mem_wr | output | 1 | Write request, held until `mem_wack` |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Merged word for a store |
| mem_rdata | input | 32 | Aligned word returned by memory |
| mem_rvalid | input | 1 | Read data valid |
| mem_wack | input | 1 | Write accepted |
| done | output | 1 | Operation complete pulse |
| ld_result | output | 32 | Merged register value of the last load |

## Verification
The embedded assertions watch the protocol on every cycle:
- memory addresses are aligned;
- read and write never overlap;
- requests stay stable until answered;
- a write only ever follows a read;
- `done` lasts a single cycle;
- the block is idle whenever it reports ready.

The byte merge itself can only be judged by the bench scenarios. The bench covers all sixteen op/offset pairs plus seeded random ones, and compares each result with a mask-and-shift reference model. The same scenarios show the live sampling of `cur_reg` at data return and that `ld_result` is retained across stores.

// File: rtl/pw_merge_pkg.sv
package pw_merge_pkg;

    // bit1 selects store, bit0 selects the right-hand variant
    typedef enum logic [1:0] {
        OP_LOAD_LEFT   = 2'b00,
        OP_LOAD_RIGHT  = 2'b01,
        OP_STORE_LEFT  = 2'b10,
        OP_STORE_RIGHT = 2'b11
    } merge_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pw_load_merge.sv
module pw_load_merge #(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic              right_sel,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] merged
);

    logic [NB-1:0][DATA_W-1:0] left_cand;
    logic [NB-1:0][DATA_W-1:0] right_cand;

    // Left: the top k+1 register bytes come from the low memory bytes.
    // Right: the low NB-k register bytes come from memory starting at byte k.
    for (genvar k = 0; k < NB; k++) begin : g_ofs
        for (genvar i = 0; i < NB; i++) begin : g_byte
            if (i >= NB - 1 - k) begin : g_lmem
                assign left_cand[k][8*i +: 8] = mem_word[8*(i-(NB-1-k)) +: 8];
            end else begin : g_lreg
                assign left_cand[k][8*i +: 8] = reg_val[8*i +: 8];
            end
            if (i <= NB - 1 - k) begin : g_rmem
                assign right_cand[k][8*i +: 8] = mem_word[8*(i+k) +: 8];
            end else begin : g_rreg
                assign right_cand[k][8*i +: 8] = reg_val[8*i +: 8];
            end
        end
    end

    assign merged = right_sel ? right_cand[ofs] : left_cand[ofs];

endmodule

// File: rtl/pw_store_merge.sv
module pw_store_merge #(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic              right_sel,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] merged
);

    logic [NB-1:0][DATA_W-1:0] left_cand;
    logic [NB-1:0][DATA_W-1:0] right_cand;

    // Left: memory bytes 0..k take the top k+1 register bytes.
    // Right: memory bytes k..NB-1 take the low register bytes.
    for (genvar k = 0; k < NB; k++) begin : g_ofs
        for (genvar i = 0; i < NB; i++) begin : g_byte
            if (i <= k) begin : g_lreg
                assign left_cand[k][8*i +: 8] = reg_val[8*(i+NB-1-k) +: 8];
            end else begin : g_lmem
                assign left_cand[k][8*i +: 8] = mem_word[8*i +: 8];
            end
            if (i >= k) begin : g_rreg
                assign right_cand[k][8*i +: 8] = reg_val[8*(i-k) +: 8];
            end else begin : g_rmem
                assign right_cand[k][8*i +: 8] = mem_word[8*i +: 8];
            end
        end
    end

    assign merged = right_sel ? right_cand[ofs] : left_cand[ofs];

endmodule

// File: rtl/pw_seq.sv
module pw_seq
    import pw_merge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic is_store,
    input  logic mem_rvalid,
    input  logic mem_wack,
    output logic req_ready,
    output logic mem_rd,
    output logic mem_wr,
    output logic done,
    output logic take_req,
    output logic take_data
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_READ;
            ST_READ:   if (mem_rvalid) state_d = is_store ? ST_WRITE : ST_FINISH;
            ST_WRITE:  if (mem_wack)   state_d = ST_FINISH;
            ST_FINISH:                 state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        done      = 1'b0;
        take_req  = 1'b0;
        take_data = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                take_req  = req_valid;
            end
            ST_READ: begin
                mem_rd    = 1'b1;
                take_data = mem_rvalid;
            end
            ST_WRITE:  mem_wr = 1'b1;
            ST_FINISH: done   = 1'b1;
            default: ;
        endcase
    end

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd && !mem_rvalid) |=> mem_rd); // R7
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_wr && !mem_wack) |=> mem_wr); // R7
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_wr) |-> $past(mem_rd)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && req_ready)); // R8
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (!mem_rd && !mem_wr && !done)); // R9

endmodule

// File: rtl/pw_merge_unit.sv
module pw_merge_unit
    import pw_merge_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] cur_reg,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    input  logic              mem_wack,
    output logic              done,
    output logic [DATA_W-1:0] ld_result
);

    merge_op_e         op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [DATA_W-1:0] wbuf_q;
    logic [DATA_W-1:0] ld_merged;
    logic [DATA_W-1:0] st_merged;
    logic              take_req;
    logic              take_data;

    pw_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .is_store   (op_q[1]),
        .mem_rvalid (mem_rvalid),
        .mem_wack   (mem_wack),
        .req_ready  (req_ready),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .done       (done),
        .take_req   (take_req),
        .take_data  (take_data)
    );

    pw_load_merge #(.DATA_W(DATA_W)) u_ld (
        .right_sel (op_q[0]),
        .ofs       (ofs_q),
        .reg_val   (cur_reg),
        .mem_word  (mem_rdata),
        .merged    (ld_merged)
    );

    pw_store_merge #(.DATA_W(DATA_W)) u_st (
        .right_sel (op_q[0]),
        .ofs       (ofs_q),
        .reg_val   (cur_reg),
        .mem_word  (mem_rdata),
        .merged    (st_merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_LOAD_LEFT;
            addr_q <= '0;
            ofs_q  <= '0;
        end else if (take_req) begin
            op_q   <= merge_op_e'(req_op);
            addr_q <= {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
            ofs_q  <= req_addr[OFS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbuf_q    <= '0;
            ld_result <= '0;
        end else if (take_data) begin
            if (op_q[1]) wbuf_q    <= st_merged;
            else         ld_result <= ld_merged;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wbuf_q;

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd || mem_wr) |-> (mem_addr[OFS_W-1:0] == '0)); // R1
    AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (mem_wr && !mem_wack) |=> ($stable(mem_wdata) && $stable(mem_addr))); // R7
    AST_RD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd && !mem_rvalid) |=> $stable(mem_addr)); // R7
    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (mem_wr |-> op_q[1])); // R7
    AST_RESULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (done && op_q[1]) |-> $stable(ld_result)); // R8

endmodule

// File: tb/pw_merge_unit_test.sv
`timescale 1ns/1ps
module pw_merge_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] cur_reg = '0;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        mem_wack = 1'b0;
    logic        done;
    logic [31:0] ld_result;

    int checks = 0;
    int failures = 0;
    logic [31:0] mem_model [0:15];
    logic [31:0] last_load = '0;

    always #10 clk = ~clk;

    pw_merge_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .cur_reg(cur_reg),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .mem_wack(mem_wack),
        .done(done), .ld_result(ld_result)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_merge(input logic [1:0] op, input logic [1:0] k,
                                              input logic [31:0] r, input logic [31:0] m);
        logic [31:0] keep;
        logic [31:0] ins;
        case (op)
            2'b00: begin // R2
                keep = r & ((k == 0) ? 32'h00FFFFFF : (k == 1) ? 32'h0000FFFF : (k == 2) ? 32'h000000FF : 32'h0);
                ins  = m << (8 * (3 - k));
            end
            2'b01: begin // R3
                keep = r & ((k == 0) ? 32'h0 : (k == 1) ? 32'hFF000000 : (k == 2) ? 32'hFFFF0000 : 32'hFFFFFF00);
                ins  = m >> (8 * k);
            end
            2'b10: begin // R4
                keep = m & ((k == 0) ? 32'hFFFFFF00 : (k == 1) ? 32'hFFFF0000 : (k == 2) ? 32'hFF000000 : 32'h0);
                ins  = r >> (8 * (3 - k));
            end
            default: begin // R5
                keep = m & ((k == 0) ? 32'h0 : (k == 1) ? 32'h000000FF : (k == 2) ? 32'h0000FFFF : 32'h00FFFFFF);
                ins  = r << (8 * k);
            end
        endcase
        return keep | ins;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] regv,
                          input int lat_r, input int lat_w);
        logic [31:0] exp;
        logic [31:0] aligned;
        string tag;
        aligned = {addr[31:2], 2'b00};
        tag = (op == 2'b00) ? "R2" : (op == 2'b01) ? "R3" : (op == 2'b10) ? "R4" : "R5";
        exp = ref_merge(op, addr[1:0], regv, mem_model[addr[5:2]]);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready idle", {31'b0, req_ready}, 32'h1);
        req_op = op; req_addr = addr; req_valid = 1'b1; cur_reg = ~regv;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 busy", {31'b0, req_ready}, 32'h0);
        chk(mem_rd == 1'b1 && mem_wr == 1'b0, "R7 read first", {30'b0, mem_rd, mem_wr}, 32'h2);
        chk(mem_addr == aligned, "R1 read addr", mem_addr, aligned);
        for (int i = 0; i < lat_r; i++) begin
            cur_reg = regv ^ 32'h5A5A5A5A;
            @(negedge clk);
        end
        chk(mem_rd == 1'b1, "R7 read held", {31'b0, mem_rd}, 32'h1);
        cur_reg = regv; mem_rdata = mem_model[addr[5:2]]; mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0; cur_reg = 32'hDEAD0000 ^ regv; mem_rdata = 32'hFFFFFFFF;
        if (op[1]) begin
            chk(mem_wr == 1'b1 && mem_rd == 1'b0, "R7 write after read", {30'b0, mem_rd, mem_wr}, 32'h1);
            chk(mem_addr == aligned, "R1 write addr", mem_addr, aligned);
            chk(mem_wdata == exp, {tag, " store merge R6"}, mem_wdata, exp);
            for (int i = 0; i < lat_w; i++) @(negedge clk);
            chk(mem_wr == 1'b1 && mem_wdata == exp, "R7 write held", mem_wdata, exp);
            mem_wack = 1'b1;
            @(negedge clk);
            mem_wack = 1'b0;
            mem_model[addr[5:2]] = mem_wdata;
            chk(done == 1'b1, "R8 done after wack", {31'b0, done}, 32'h1);
            chk(ld_result == last_load, "R8 result kept", ld_result, last_load);
        end else begin
            chk(mem_wr == 1'b0, "R7 load no write", {31'b0, mem_wr}, 32'h0);
            chk(done == 1'b1, "R8 done after data", {31'b0, done}, 32'h1);
            chk(ld_result == exp, {tag, " load merge R6"}, ld_result, exp);
            last_load = exp;
        end
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R8 single pulse", {30'b0, done, req_ready}, 32'h1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem_model[i] = 32'hA0B0C0D0 + i * 32'h01010101;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && mem_rd == 1'b0 && mem_wr == 1'b0 && done == 1'b0,
            "R9 reset outputs", {28'b0, req_ready, mem_rd, mem_wr, done}, 32'h8);
        chk(ld_result == 32'h0, "R9 reset result", ld_result, 32'h0);
        rst_n = 1'b1;
        // directed: every op and every offset (R1..R5)
        for (int op = 0; op < 4; op++) begin
            for (int k = 0; k < 4; k++) begin
                run_op(op[1:0], 32'h8000_0010 + k, 32'h11223344, k % 2, k / 2);
            end
        end
        // random mix
        for (int n = 0; n < 300; n++) begin
            run_op($urandom_range(0, 3), $urandom, $urandom, $urandom_range(0, 3), $urandom_range(0, 3));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule